// File: doc/BRIEF.md
# SPI Status-Register Write-Protect Controller

This block is the command front end of a serial flash device that decides whether the block-protect bits and the lock bit of the status register may change. It watches the SPI pins (serial clock, active-low chip select, serial data in) together with an active-low hardware write-protect pin. All four pins are brought into the local clock domain through a synchronizer. Serial data is taken on each rising serial-clock edge while chip select is low, in SPI mode 0 or mode 3.

Changing the status register takes two framed commands. First comes an arming opcode, then the status-write opcode with its data byte. Nothing takes effect until chip select rises at the end of a frame. At that moment the block checks the frame length, the opcode, the armed flag, the write-protect pin and the current lock bit. It then sets the armed flag, clears it, or commits new protect and lock bits. While the write-protect pin is low, the lock bit becomes a one-way latch.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the four protect bits, the lock bit and the armed flag are all 0.
- R2: A frame of exactly 8 bits whose opcode is 0x50 or 0x06 sets the armed flag when chip select rises, and not before.
- R3: A frame of exactly 16 bits, opcode 0x01 followed by a data byte, shifted MSB first, writes the status bits when the block is armed. Data bit 7 goes to the lock bit. Data bits 5, 4, 3 and 2 go to protect bits 3, 2, 1 and 0. Data bits 6, 1 and 0 are ignored.
- R4: A status-write frame received while not armed changes no status bit.
- R5: Any other complete frame (a nonzero multiple of 8 bits) clears the armed flag. A chip-select pulse with no serial-clock edges is not a command and leaves the armed flag as it was.
- R6: When write-protect is low and the lock bit is 1 as chip select rises, a status write changes neither the lock bit nor the protect bits.
- R7: When write-protect is low and the lock bit is 0, an armed status write updates the protect bits and may set the lock bit, both in the same write.
- R8: When write-protect is high, an armed status write sets or clears the lock bit and all protect bits freely.
- R9: A frame whose bit count is not a multiple of 8, or an 0x01 frame of any length other than 16 bits, is discarded and clears the armed flag.
- R10: Every 16-bit status-write frame clears the armed flag, whether it was applied or ignored.
- R11: The write-protect level that counts is the one present when chip select rises. Changes during the frame have no effect of their own.
- R12: Serial-clock edges while chip select is high are neither counted nor shifted. Mode 0 and mode 3 framing give the same result.
- R13: The status bits and the armed flag change only in response to the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select that frames each command |
| si | input | 1 | Serial data in, MSB first |
| wpN | input | 1 | Active-low hardware write-protect pin |
| bpOut | output | 4 | Block-protect bits, bit 0 is the lowest |
| lockOut | output | 1 | Lock bit |
| armedOut | output | 1 | Armed flag: the next status write is allowed |

## Verification
The embedded properties check the following on every cycle:
- the lock bit holds while write-protect is low;
- the protect bits stay frozen under a pin-backed lock;
- status bits move only on a commit strobe;
- the armed flag rises only from an arming strobe;
- a commit is never issued unless armed, and always disarms;
- the bit counter stays cleared while deselected.

Some behaviours only the bench scenarios can show. These are the bit-to-field mapping of the data byte, and the classification of short, odd and overlong frames. They also include the point at which the write-protect level counts, the equivalence of mode 0 and mode 3, and how serial-clock edges outside a frame are handled. The bench drives those scenarios against a behavioural reference model and compares outputs on every clock.

// File: rtl/spi_status_guard_pkg.sv
package spi_status_guard_pkg;

  localparam int OP_W     = 8;
  localparam int FRAME_W  = 2 * OP_W;
  localparam int LOCK_BIT = 7;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 4;

  localparam logic [OP_W-1:0] OP_ARM_STATUS = 8'h50;
  localparam logic [OP_W-1:0] OP_ARM_WRITE  = 8'h06;
  localparam logic [OP_W-1:0] OP_STATUS_WR  = 8'h01;

  typedef enum logic [1:0] {
    FR_EMPTY,
    FR_ARM,
    FR_WRITE,
    FR_OTHER
  } frameKind_t;

  typedef struct packed {
    logic shift;
    logic armSet;
    logic armClr;
    logic statusWr;
  } dpCmd_t;

endpackage

// File: rtl/spi_status_guard_sync.sv
module spi_status_guard_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipeQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipeQ[s] <= RESET_VAL;
    end else begin
      pipeQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) pipeQ[s] <= pipeQ[s-1];
    end
  end

  assign syncOut = pipeQ[STAGES-1];

endmodule

// File: rtl/spi_status_guard_ctrl.sv
module spi_status_guard_ctrl
  import spi_status_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sckS,
  input  logic               csNS,
  input  logic               armedQ,
  input  logic [FRAME_W-1:0] shiftWord,
  output dpCmd_t             cmd
);

  localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);

  logic             sckPrevQ;
  logic             csPrevQ;
  logic [CNT_W-1:0] bitCnt;
  logic             sckRise;
  logic             csRise;
  logic [OP_W-1:0]  shortOp;
  logic [OP_W-1:0]  longOp;
  frameKind_t       frameKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrevQ <= 1'b0;
      csPrevQ  <= 1'b1;
    end else begin
      sckPrevQ <= sckS;
      csPrevQ  <= csNS;
    end
  end

  assign sckRise = sckS && !sckPrevQ;
  assign csRise  = csNS && !csPrevQ;

  // bit counter saturates so that overlong frames never alias a legal length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csNS) begin
      bitCnt <= '0;
    end else if (sckRise && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign shortOp = shiftWord[OP_W-1:0];
  assign longOp  = shiftWord[FRAME_W-1 -: OP_W];

  always_comb begin
    if (bitCnt == '0) begin
      frameKind = FR_EMPTY;
    end else if (bitCnt == CNT_OP &&
                 (shortOp == OP_ARM_STATUS || shortOp == OP_ARM_WRITE)) begin
      frameKind = FR_ARM;
    end else if (bitCnt == CNT_FRAME && longOp == OP_STATUS_WR) begin
      frameKind = FR_WRITE;
    end else begin
      frameKind = FR_OTHER;
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.shift    = sckRise && !csNS;
    cmd.armSet   = csRise && (frameKind == FR_ARM);
    cmd.statusWr = csRise && (frameKind == FR_WRITE) && armedQ;
    cmd.armClr   = csRise && ((frameKind == FR_OTHER) ||
                              (frameKind == FR_WRITE && !armedQ));
  end

  // R12: deselect keeps the counter cleared
  p_count_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    csNS |=> (bitCnt == '0));

  // R9: a frame end yields at most one action
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.armSet, cmd.armClr, cmd.statusWr}));

  // R12: no data shifted while deselected
  p_no_shift_deselected_r12: assert property (@(posedge clk) disable iff (!rstN)
    csNS |-> !cmd.shift);

endmodule

// File: rtl/spi_status_guard_dp.sv
module spi_status_guard_dp
  import spi_status_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               siS,
  input  logic               wpNS,
  output logic [FRAME_W-1:0] shiftWord,
  output logic [BP_W-1:0]    bpQ,
  output logic               lockQ,
  output logic               armedQ
);

  logic pinLocked;

  assign pinLocked = !wpNS && lockQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (cmd.shift) begin
      shiftWord <= {shiftWord[FRAME_W-2:0], siS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (cmd.statusWr || cmd.armClr) begin
      armedQ <= 1'b0;
    end else if (cmd.armSet) begin
      armedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ   <= '0;
      lockQ <= 1'b0;
    end else if (cmd.statusWr && !pinLocked) begin
      bpQ   <= shiftWord[BP_LSB +: BP_W];
      lockQ <= shiftWord[LOCK_BIT];
    end
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !wpNS) |=> lockQ);

  p_bp_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !wpNS) |=> $stable(bpQ));

  p_status_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.statusWr |=> ($stable(bpQ) && $stable(lockQ)));

  p_arm_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(cmd.armSet));

  p_write_needs_arm_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.statusWr |-> armedQ);

  p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.statusWr |=> !armedQ);

endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import spi_status_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sck,
  input  logic            csN,
  input  logic            si,
  input  logic            wpN,
  output logic [BP_W-1:0] bpOut,
  output logic            lockOut,
  output logic            armedOut
);

  logic [3:0]         pinsS;
  logic               sckS;
  logic               csNS;
  logic               siS;
  logic               wpNS;
  dpCmd_t             cmd;
  logic [FRAME_W-1:0] shiftWord;

  spi_status_guard_sync #(
    .WIDTH(4),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(4'b0101)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({sck, csN, si, wpN}),
    .syncOut(pinsS)
  );

  assign {sckS, csNS, siS, wpNS} = pinsS;

  spi_status_guard_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sckS(sckS),
    .csNS(csNS),
    .armedQ(armedOut),
    .shiftWord(shiftWord),
    .cmd(cmd)
  );

  spi_status_guard_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .siS(siS),
    .wpNS(wpNS),
    .shiftWord(shiftWord),
    .bpQ(bpOut),
    .lockQ(lockOut),
    .armedQ(armedOut)
  );

endmodule

// File: tb/spi_status_guard_bench.sv
module spi_status_guard_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       csN = 1'b1;
  logic       si = 1'b0;
  logic       wpN = 1'b1;
  logic [3:0] bpOut;
  logic       lockOut;
  logic       armedOut;

  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;
  int   hiCnt = 0;

  // behavioural reference state
  logic [3:0] mBp = '0;
  logic       mLock = 1'b0;
  logic       mArmed = 1'b0;

  always #2 clk = ~clk;

  spi_status_guard u_spi_status_guard (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .wpN(wpN),
    .bpOut(bpOut), .lockOut(lockOut), .armedOut(armedOut)
  );

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int expBp, input int expLock, input int expArmed);
    checkVal(tag, "bp", int'(bpOut), expBp);
    checkVal(tag, "lock", int'(lockOut), expLock);
    checkVal(tag, "armed", int'(armedOut), expArmed);
  endtask

  task automatic modelEnd(input logic [31:0] word, input int nBits);
    if (nBits == 0) begin
    end else if (nBits == 8 && (word[7:0] == 8'h50 || word[7:0] == 8'h06)) begin
      mArmed = 1'b1;
    end else if (nBits == 16 && word[15:8] == 8'h01) begin
      if (mArmed && !(!wpN && mLock)) begin
        mBp   = word[5:2];
        mLock = word[7];
      end
      mArmed = 1'b0;
    end else begin
      mArmed = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [31:0] word, input int nBits, input bit mode3,
                           input int wpBit, input logic wpLevel);
    @(negedge clk);
    sck = mode3;
    repeat (3) @(negedge clk);
    csN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = nBits - 1; i >= 0; i--) begin
      if ((nBits - 1 - i) == wpBit) wpN = wpLevel;
      sck = 1'b0;
      si  = word[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
    if (!mode3) begin
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    modelEnd(word, nBits);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] word, input int nBits);
    sendFrame(word, nBits, 1'b0, -1, 1'b0);
  endtask

  // cycle-by-cycle comparison against the reference, away from the edge
  always @(posedge clk) begin
    #1;
    if (csN) begin
      if (hiCnt < 1000) hiCnt++;
    end else begin
      hiCnt = 0;
    end
    if (rstN && !done && (!csN || hiCnt >= 4)) begin
      tests++;
      if (bpOut !== mBp || lockOut !== mLock || armedOut !== mArmed) begin
        fails++;
        $display("FAIL R13 per-cycle actual=%h/%b/%b expected=%h/%b/%b",
                 bpOut, lockOut, armedOut, mBp, mLock, mArmed);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checkAll("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkAll("R1 after reset", 0, 0, 0);

    frame(32'h019C, 16);
    checkAll("R4 unarmed write", 0, 0, 0);

    frame(32'h06, 8);
    checkAll("R2 arm 0x06", 0, 0, 1);
    frame(32'h013C, 16);
    checkAll("R3 R10 write all bp", 4'hF, 0, 0);

    sendFrame(32'h50, 8, 1'b1, -1, 1'b0);
    checkAll("R2 R12 arm 0x50 mode3", 4'hF, 0, 1);
    sendFrame(32'h0147, 16, 1'b1, -1, 1'b0);
    checkAll("R3 R12 unused bits mode3", 4'h1, 0, 0);

    frame(32'h06, 8);
    frame(32'h05, 8);
    checkAll("R5 other command disarms", 4'h1, 0, 0);
    frame(32'h013C, 16);
    checkAll("R5 write after disarm", 4'h1, 0, 0);

    frame(32'h06, 8);
    frame(32'h0, 0);
    checkAll("R5 empty frame keeps arm", 4'h1, 0, 1);
    frame(32'h0100, 16);
    checkAll("R5 write after empty frame", 4'h0, 0, 0);

    frame(32'h06, 8);
    frame(32'h123, 12);
    checkAll("R9 12-bit frame", 4'h0, 0, 0);
    frame(32'h06, 8);
    frame(32'h01, 8);
    checkAll("R9 short write", 4'h0, 0, 0);
    frame(32'h06, 8);
    frame(32'h01FC00, 24);
    checkAll("R9 long write", 4'h0, 0, 0);

    wpN = 1'b0;
    frame(32'h06, 8);
    frame(32'h01A8, 16);
    checkAll("R7 wp low lock set", 4'hA, 1, 0);

    frame(32'h50, 8);
    checkAll("R6 armed before locked write", 4'hA, 1, 1);
    frame(32'h0104, 16);
    checkAll("R6 R10 locked write ignored", 4'hA, 1, 0);

    wpN = 1'b1;
    frame(32'h06, 8);
    frame(32'h0100, 16);
    checkAll("R8 wp high clears lock", 4'h0, 0, 0);

    frame(32'h06, 8);
    frame(32'h0180, 16);
    checkAll("R8 wp high sets lock", 4'h0, 1, 0);
    frame(32'h06, 8);
    sendFrame(32'h013C, 16, 1'b0, 10, 1'b0);
    checkAll("R11 wp falls mid-frame", 4'h0, 1, 0);
    frame(32'h06, 8);
    sendFrame(32'h0108, 16, 1'b0, 10, 1'b1);
    checkAll("R11 wp rises mid-frame", 4'h2, 0, 0);

    frame(32'h06, 8);
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    checkAll("R12 idle clocks keep arm", 4'h2, 0, 1);
    frame(32'h0114, 16);
    checkAll("R12 idle clocks not counted", 4'h5, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule